// File: doc/BRIEF.md
# Translation Context Register Bank

This block is the software-visible face of an I/O translation unit. It holds the settings for a set of translation contexts behind a 32-bit register bus: address, write enable, write data and a read-data return that follows the address in the same cycle. Each context has its own 64-byte window. The whole bank is also mirrored a second time, 0x800 bytes higher.

Every context has:

- a control word with translate-enable, interrupt-enable and invalidate bits;
- table-base and table-control words;
- a walk-bus word and two memory-attribute words;
- a fault status word and a fault address word.

A TLB model outside the block receives a one-cycle invalidate kick from this block and answers with a done pulse. Until that pulse arrives, the invalidate bit reads as busy. A walker outside the block reports faults, each with a context, a type, an error code, a walk level and a virtual address. The block latches the first fault per context and keeps it until software clears it. Any write to the status word clears it, and the clear also wipes the latched address. Software therefore reads the address first. A single interrupt line goes high when any context with interrupts enabled holds a fault.

Top module: `xlat_ctx_regfile`

## Requirements
- R1: Context n occupies byte offsets n*0x40 to n*0x40+0x3F. Address bit 11 is ignored, so an access at 0x800 plus an offset reaches the same register as the offset itself.
- R2: The bank has two kinds of unmapped location. One is a context window at or beyond NUM_CTX (address bits 10:6 >= NUM_CTX). The other is an unassigned offset inside a window (0x04, 0x18, 0x1C, 0x24, 0x34 and above). Unmapped locations read 0 and ignore writes.
- R3: The control word (offset 0x00) stores write-data bits 0, 2, 3, 5:4, 16 and 17 (mask 0x0003003D). Bit 1 reads back the invalidate-busy state.
- R4: A control write with bit 1 set to an idle context sets busy. In the following cycle, and in that cycle only, the context's flushStart bit is high.
- R5: Busy drops on the clock edge that samples flushDone for that context. A flushDone while the context is idle changes nothing.
- R6: A control write with bit 1 set while busy is merged into the running invalidate. There is no new flushStart, and the one flushDone ends it.
- R7: A fault report on a context with no flag set does all of the following: sets the flag for its type (0 = bit 0 translation, 1 = bit 1 permission, 2 = bit 2 walk abort, 3 = bit 4 multiple hit); stores the code in status bits 10:8 and the level in bits 13:12; stores the address at offset 0x30. The status word is at offset 0x20.
- R8: A fault report on a context that already has a flag set ORs in its own flag only. The stored code, level and address are kept.
- R9: A write of any value to the status word clears it, including 0 and the value just read. The same write clears the fault address, so a later read of it returns 0. A fault report in the same cycle as the clear is captured fresh.
- R10: irq is high exactly when some context has control bit 2 set and at least one fault flag set.
- R11: The stored widths are as follows: table control (0x08), table base low (0x10) and both attribute words (0x28, 0x2C) keep all 32 bits; the walk-bus word (0x0C) keeps bits 2:0; table base high (0x14) keeps bits 7:0, giving a 40-bit base.
- R12: After reset every register reads 0, irq is low and no flushStart is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register byte address |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| flushStart | output | NUM_CTX | One-cycle invalidate kick per context |
| flushDone | input | NUM_CTX | Invalidate-finished pulse per context |
| faultValid | input | 1 | Fault report strobe |
| faultCtx | input | CTX_W | Context of the fault |
| faultType | input | 2 | Fault type: 0 translation, 1 permission, 2 walk abort, 3 multiple hit |
| faultCode | input | 3 | Error code to store |
| faultLevel | input | 2 | Walk level to store |
| faultAddr | input | 32 | Faulting virtual address |
| irq | output | 1 | Combined interrupt |

## Verification
The properties rely on three assumptions about the inputs:

- flushDone is a single-cycle pulse.
- faultCtx names an existing context.
- The fault and bus inputs hold steady across each sampling edge.

The bench meets these by driving all inputs a moment after the falling edge and dropping every strobe after one cycle. The check that a stored fault address is held only applies in cycles with no bus write, because a status write may legally clear it. The bench also sends some faults in cycles with no bus traffic so that this check is exercised.

// File: rtl/xlat_ctx_pkg.sv
package xlat_ctx_pkg;

  typedef enum logic [3:0] {
    REG_NONE, REG_CTRL, REG_TTBCR, REG_BUS, REG_TTLO,
    REG_TTHI, REG_STAT, REG_ATTR0, REG_ATTR1, REG_FADDR
  } regId_e;

  // strobes handed from the decoder to the register datapath
  typedef struct packed {
    regId_e regId;
    logic   hit;
    logic   wr;
  } busStrobe_t;

  localparam int WIN_W = 6;                       // 64-byte context window
  localparam logic [31:0] CTRL_WMASK = 32'h0003_003D;
  localparam int FLUSH_BIT = 1;
  localparam int INTEN_BIT = 2;

  // internal flag order: [0] translation, [1] permission, [2] walk abort, [3] multi hit
  function automatic logic [3:0] faultFlag(input logic [1:0] kind);
    return 4'b0001 << kind;
  endfunction

endpackage

// File: rtl/xlat_ctx_ctrl.sv
module xlat_ctx_ctrl
  import xlat_ctx_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int ADDR_W  = 12,
  parameter int CTX_W   = 2
) (
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic               faultValid,
  input  logic [CTX_W-1:0]   faultCtx,
  output busStrobe_t         strobe,
  output logic [CTX_W-1:0]   ctxIdx,
  output logic [NUM_CTX-1:0] ctxHot,
  output logic [NUM_CTX-1:0] faultHot
);
  localparam int ALIAS_BIT = ADDR_W - 1;
  localparam int UP_W      = ALIAS_BIT - WIN_W;

  logic [UP_W-1:0] winNum;
  logic            winOk;
  regId_e          regId;

  assign winNum = busAddr[ALIAS_BIT-1:WIN_W];
  assign winOk  = winNum < UP_W'(NUM_CTX);
  assign ctxIdx = winNum[CTX_W-1:0];

  always_comb begin
    unique case (busAddr[WIN_W-1:0])
      6'h00:   regId = REG_CTRL;
      6'h08:   regId = REG_TTBCR;
      6'h0C:   regId = REG_BUS;
      6'h10:   regId = REG_TTLO;
      6'h14:   regId = REG_TTHI;
      6'h20:   regId = REG_STAT;
      6'h28:   regId = REG_ATTR0;
      6'h2C:   regId = REG_ATTR1;
      6'h30:   regId = REG_FADDR;
      default: regId = REG_NONE;
    endcase
  end

  assign strobe.regId = regId;
  assign strobe.hit   = winOk && (regId != REG_NONE);
  assign strobe.wr    = busWrEn && strobe.hit;
  assign ctxHot       = strobe.hit ? (NUM_CTX'(1) << ctxIdx) : '0;

  logic faultOk;
  assign faultOk  = faultValid && ({1'b0, faultCtx} < (CTX_W+1)'(NUM_CTX));
  assign faultHot = faultOk ? (NUM_CTX'(1) << faultCtx) : '0;
endmodule

// File: rtl/xlat_ctx_dp.sv
module xlat_ctx_dp
  import xlat_ctx_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int CTX_W   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  busStrobe_t            strobe,
  input  logic [CTX_W-1:0]      ctxIdx,
  input  logic [NUM_CTX-1:0]    ctxHot,
  input  logic [NUM_CTX-1:0]    faultHot,
  input  logic [31:0]           busWdata,
  input  logic [1:0]            faultType,
  input  logic [2:0]            faultCode,
  input  logic [1:0]            faultLevel,
  input  logic [31:0]           faultAddr,
  input  logic [NUM_CTX-1:0]    flushDone,
  output logic [31:0]           busRdata,
  output logic [NUM_CTX-1:0]    flushStart,
  output logic [NUM_CTX-1:0]    busyVec,
  output logic [NUM_CTX-1:0]    flagAnyVec,
  output logic [NUM_CTX*32-1:0] faddrFlat,
  output logic                  irq
);
  logic [31:0]        rdWord [NUM_CTX];
  logic [NUM_CTX-1:0] irqVec;

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    logic [31:0] ctrlQ, ttbcrQ, ttLoQ, attr0Q, attr1Q, faddrQ;
    logic [7:0]  ttHiQ;
    logic [2:0]  busQ, codeQ;
    logic [1:0]  lvlQ;
    logic [3:0]  flagQ;
    logic        busyQ, kickQ;
    logic        wrSel, wrCtrl, wrStat, capt;

    assign wrSel  = strobe.wr && ctxHot[c];
    assign wrCtrl = wrSel && strobe.regId == REG_CTRL;
    assign wrStat = wrSel && strobe.regId == REG_STAT;
    assign capt   = faultHot[c];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrlQ <= '0; ttbcrQ <= '0; ttLoQ <= '0; ttHiQ <= '0; busQ <= '0;
        attr0Q <= '0; attr1Q <= '0; faddrQ <= '0; codeQ <= '0; lvlQ <= '0;
        flagQ <= '0; busyQ <= 1'b0; kickQ <= 1'b0;
      end else begin
        kickQ <= 1'b0;
        if (wrCtrl) ctrlQ <= busWdata & CTRL_WMASK;
        if (wrSel && strobe.regId == REG_TTBCR) ttbcrQ <= busWdata;
        if (wrSel && strobe.regId == REG_BUS)   busQ   <= busWdata[2:0];
        if (wrSel && strobe.regId == REG_TTLO)  ttLoQ  <= busWdata;
        if (wrSel && strobe.regId == REG_TTHI)  ttHiQ  <= busWdata[7:0];
        if (wrSel && strobe.regId == REG_ATTR0) attr0Q <= busWdata;
        if (wrSel && strobe.regId == REG_ATTR1) attr1Q <= busWdata;
        // invalidate tracker: a request while busy merges into the running one
        if (busyQ) begin
          if (flushDone[c]) busyQ <= 1'b0;
        end else if (wrCtrl && busWdata[FLUSH_BIT]) begin
          busyQ <= 1'b1;
          kickQ <= 1'b1;
        end
        // fault latch: first fault owns code, level and address
        if (capt && (wrStat || flagQ == 4'd0)) begin
          flagQ  <= faultFlag(faultType);
          codeQ  <= faultCode;
          lvlQ   <= faultLevel;
          faddrQ <= faultAddr;
        end else if (capt) begin
          flagQ <= flagQ | faultFlag(faultType);
        end else if (wrStat) begin
          flagQ <= '0; codeQ <= '0; lvlQ <= '0; faddrQ <= '0;
        end
      end
    end

    logic [31:0] statWord;
    assign statWord = {18'd0, lvlQ, 1'b0, codeQ, 3'd0, flagQ[3], 1'b0,
                       flagQ[2], flagQ[1], flagQ[0]};

    always_comb begin
      unique case (strobe.regId)
        REG_CTRL:  rdWord[c] = ctrlQ | (32'(busyQ) << FLUSH_BIT);
        REG_TTBCR: rdWord[c] = ttbcrQ;
        REG_BUS:   rdWord[c] = {29'd0, busQ};
        REG_TTLO:  rdWord[c] = ttLoQ;
        REG_TTHI:  rdWord[c] = {24'd0, ttHiQ};
        REG_STAT:  rdWord[c] = statWord;
        REG_ATTR0: rdWord[c] = attr0Q;
        REG_ATTR1: rdWord[c] = attr1Q;
        REG_FADDR: rdWord[c] = faddrQ;
        default:   rdWord[c] = '0;
      endcase
    end

    assign flushStart[c]          = kickQ;
    assign busyVec[c]             = busyQ;
    assign flagAnyVec[c]          = |flagQ;
    assign irqVec[c]              = ctrlQ[INTEN_BIT] && (|flagQ);
    assign faddrFlat[c*32 +: 32]  = faddrQ;
  end

  assign busRdata = strobe.hit ? rdWord[ctxIdx] : 32'd0;
  assign irq      = |irqVec;
endmodule

// File: rtl/xlat_ctx_regfile.sv
module xlat_ctx_regfile
  import xlat_ctx_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int ADDR_W  = 12,
  localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  output logic [NUM_CTX-1:0] flushStart,
  input  logic [NUM_CTX-1:0] flushDone,
  input  logic               faultValid,
  input  logic [CTX_W-1:0]   faultCtx,
  input  logic [1:0]         faultType,
  input  logic [2:0]         faultCode,
  input  logic [1:0]         faultLevel,
  input  logic [31:0]        faultAddr,
  output logic               irq
);
  busStrobe_t            strobe;
  logic [CTX_W-1:0]      ctxIdx;
  logic [NUM_CTX-1:0]    ctxHot, faultHot, busyVec, flagAnyVec;
  logic [NUM_CTX*32-1:0] faddrFlat;

  xlat_ctx_ctrl #(.NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W), .CTX_W(CTX_W)) u_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .faultValid(faultValid),
    .faultCtx(faultCtx), .strobe(strobe), .ctxIdx(ctxIdx),
    .ctxHot(ctxHot), .faultHot(faultHot)
  );

  xlat_ctx_dp #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .ctxIdx(ctxIdx),
    .ctxHot(ctxHot), .faultHot(faultHot), .busWdata(busWdata),
    .faultType(faultType), .faultCode(faultCode), .faultLevel(faultLevel),
    .faultAddr(faultAddr), .flushDone(flushDone), .busRdata(busRdata),
    .flushStart(flushStart), .busyVec(busyVec), .flagAnyVec(flagAnyVec),
    .faddrFlat(faddrFlat), .irq(irq)
  );
endmodule

// File: rtl/xlat_ctx_regfile_chk.sv
module xlat_ctx_regfile_chk #(
  parameter int NUM_CTX = 4,
  parameter int CTX_W   = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busWrEn,
  input logic                  faultValid,
  input logic [CTX_W-1:0]      faultCtx,
  input logic [NUM_CTX-1:0]    flushStart,
  input logic [NUM_CTX-1:0]    flushDone,
  input logic [NUM_CTX-1:0]    busyVec,
  input logic [NUM_CTX-1:0]    flagAnyVec,
  input logic [NUM_CTX*32-1:0] faddrFlat,
  input logic                  irq
);
  for (genvar c = 0; c < NUM_CTX; c++) begin : g_chk
    // R5
    flush_done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busyVec[c] && flushDone[c] |=> !busyVec[c]);
    // R4
    flush_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flushStart[c] |=> !flushStart[c]);
    // R4
    flush_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flushStart[c] |-> busyVec[c]);
    // R6
    flush_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flushStart[c] |-> !$past(busyVec[c]));
    // R8
    fault_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flagAnyVec[c] && faultValid && faultCtx == CTX_W'(c) && !busWrEn
      |=> $stable(faddrFlat[c*32 +: 32]));
  end

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flagAnyVec == '0 |-> !irq);
endmodule

bind xlat_ctx_regfile xlat_ctx_regfile_chk #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .faultValid(faultValid),
  .faultCtx(faultCtx), .flushStart(flushStart), .flushDone(flushDone),
  .busyVec(busyVec), .flagAnyVec(flagAnyVec), .faddrFlat(faddrFlat), .irq(irq)
);

// File: tb/xlat_ctx_regfile_bench.sv
module xlat_ctx_regfile_bench;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [NC-1:0] flushStart;
  logic [NC-1:0] flushDone = '0;
  logic        faultValid = 1'b0;
  logic [1:0]  faultCtx = '0;
  logic [1:0]  faultType = '0;
  logic [2:0]  faultCode = '0;
  logic [1:0]  faultLevel = '0;
  logic [31:0] faultAddr = '0;
  logic        irq;

  int checks = 0;
  int failures = 0;

  xlat_ctx_regfile u_xlat_ctx_regfile (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWdata(busWdata), .busRdata(busRdata), .flushStart(flushStart),
    .flushDone(flushDone), .faultValid(faultValid), .faultCtx(faultCtx),
    .faultType(faultType), .faultCode(faultCode), .faultLevel(faultLevel),
    .faultAddr(faultAddr), .irq(irq)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  int mCtrl[NC], mTtbcr[NC], mBus[NC], mTtLo[NC], mTtHi[NC], mAttr0[NC], mAttr1[NC];
  int mFlags[NC], mCode[NC], mLvl[NC], mFaddr[NC], mBusy[NC], mStart[NC];

  function automatic int flagBit(int t);
    case (t)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return 16;
    endcase
  endfunction

  function automatic logic [31:0] mRead(logic [11:0] a);
    int n;
    if (a[10:8] != 0) return 0;
    n = int'(a[7:6]);
    case (a[5:0])
      6'h00: return mCtrl[n] | (mBusy[n] << 1);
      6'h08: return mTtbcr[n];
      6'h0C: return mBus[n];
      6'h10: return mTtLo[n];
      6'h14: return mTtHi[n];
      6'h20: return mFlags[n] | (mCode[n] << 8) | (mLvl[n] << 12);
      6'h28: return mAttr0[n];
      6'h2C: return mAttr1[n];
      6'h30: return mFaddr[n];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    for (int n = 0; n < NC; n++) begin
      if (!rst_n) begin
        mCtrl[n] = 0; mTtbcr[n] = 0; mBus[n] = 0; mTtLo[n] = 0; mTtHi[n] = 0;
        mAttr0[n] = 0; mAttr1[n] = 0; mFlags[n] = 0; mCode[n] = 0; mLvl[n] = 0;
        mFaddr[n] = 0; mBusy[n] = 0; mStart[n] = 0;
      end else begin
        int wasBusy;
        logic hitN, wStat;
        wasBusy = mBusy[n];
        mStart[n] = 0;
        hitN = busWrEn && busAddr[10:8] == 0 && int'(busAddr[7:6]) == n;
        wStat = hitN && busAddr[5:0] == 6'h20;
        if (wasBusy != 0 && flushDone[n]) mBusy[n] = 0;
        if (hitN) begin
          case (busAddr[5:0])
            6'h00: begin
              mCtrl[n] = busWdata & 32'h0003_003D;
              if (wasBusy == 0 && busWdata[1]) begin mBusy[n] = 1; mStart[n] = 1; end
            end
            6'h08: mTtbcr[n] = busWdata;
            6'h0C: mBus[n] = busWdata & 7;
            6'h10: mTtLo[n] = busWdata;
            6'h14: mTtHi[n] = busWdata & 8'hFF;
            6'h28: mAttr0[n] = busWdata;
            6'h2C: mAttr1[n] = busWdata;
            default: ;
          endcase
        end
        if (wStat) begin mFlags[n] = 0; mCode[n] = 0; mLvl[n] = 0; mFaddr[n] = 0; end
        if (faultValid && int'(faultCtx) == n) begin
          if (mFlags[n] == 0) begin
            mFlags[n] = flagBit(int'(faultType)); mCode[n] = int'(faultCode);
            mLvl[n] = int'(faultLevel); mFaddr[n] = faultAddr;
          end else mFlags[n] = mFlags[n] | flagBit(int'(faultType));
        end
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic expIrq;
      logic [NC-1:0] expStart;
      expIrq = 1'b0;
      for (int n = 0; n < NC; n++) begin
        expStart[n] = mStart[n] != 0;
        if (mCtrl[n][2] && mFlags[n] != 0) expIrq = 1'b1;
      end
      check("R1 readback vs model", busRdata, mRead(busAddr));
      check("R10 irq vs model", {31'd0, irq}, {31'd0, expIrq});
      check("R4 flushStart vs model", {28'd0, flushStart}, {28'd0, expStart});
    end
  end

  task automatic busWrite(logic [11:0] a, logic [31:0] d);
    @(negedge clk); #1;
    busAddr = a; busWdata = d; busWrEn = 1'b1;
    @(negedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic readCheck(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk); #1;
    busAddr = a; busWrEn = 1'b0;
    #1;
    check(tag, busRdata, exp);
  endtask

  task automatic sendFault(logic [1:0] c, logic [1:0] t, logic [2:0] code,
                           logic [1:0] lvl, logic [31:0] a);
    @(negedge clk); #1;
    faultValid = 1'b1; faultCtx = c; faultType = t; faultCode = code;
    faultLevel = lvl; faultAddr = a;
    @(negedge clk); #1;
    faultValid = 1'b0;
  endtask

  task automatic pulseDone(logic [NC-1:0] v);
    @(negedge clk); #1;
    flushDone = v;
    @(negedge clk); #1;
    flushDone = '0;
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;

    // R12 reset state
    readCheck(12'h000, 32'h0, "R12 ctrl after reset");
    readCheck(12'h0E0, 32'h0, "R12 status after reset");
    check("R12 irq after reset", {31'd0, irq}, 32'h0);
    check("R12 flushStart after reset", {28'd0, flushStart}, 32'h0);

    // R1 window spacing and alias
    busWrite(12'h090, 32'hDEAD_BEEF);
    readCheck(12'h890, 32'hDEAD_BEEF, "R1 alias read ctx2 base low");
    busWrite(12'h8D0, 32'h1357_9BDF);
    readCheck(12'h0D0, 32'h1357_9BDF, "R1 alias write ctx3 base low");
    readCheck(12'h010, 32'h0, "R1 ctx0 base low untouched");

    // R11 widths
    busWrite(12'h054, 32'hFFFF_FFFF);
    readCheck(12'h054, 32'h0000_00FF, "R11 base high 8 bits");
    busWrite(12'h04C, 32'hFFFF_FFFF);
    readCheck(12'h04C, 32'h0000_0007, "R11 bus word 3 bits");
    busWrite(12'h048, 32'h8000_0010);
    readCheck(12'h048, 32'h8000_0010, "R11 table control");
    busWrite(12'h06C, 32'hA5A5_5A5A);
    readCheck(12'h06C, 32'hA5A5_5A5A, "R11 attribute word");

    // R2 unmapped
    busWrite(12'h110, 32'h1111_2222);
    readCheck(12'h110, 32'h0, "R2 window beyond NUM_CTX");
    readCheck(12'h010, 32'h0, "R2 no alias into ctx0");
    busWrite(12'h004, 32'hFFFF_FFFF);
    readCheck(12'h004, 32'h0, "R2 unassigned offset");
    readCheck(12'h000, 32'h0, "R2 ctrl untouched by unmapped write");

    // R3 control mask
    busWrite(12'h000, 32'hFFFF_FFFD);
    readCheck(12'h000, 32'h0003_003D, "R3 control mask");
    busWrite(12'h000, 32'h0);

    // R4 flush kick
    busWrite(12'h040, 32'h0000_0002);
    check("R4 flushStart pulse", {28'd0, flushStart}, 32'h2);
    readCheck(12'h040, 32'h0000_0002, "R4 busy reads 1");
    check("R4 flushStart single cycle", {28'd0, flushStart}, 32'h0);

    // R6 merge while busy
    busWrite(12'h040, 32'h0000_0002);
    check("R6 no second kick", {28'd0, flushStart}, 32'h0);
    readCheck(12'h040, 32'h0000_0002, "R6 still busy");

    // R5 done clears busy; done while idle ignored
    pulseDone(4'b0110);
    readCheck(12'h040, 32'h0, "R5 busy cleared after done");
    readCheck(12'h080, 32'h0, "R5 idle done no effect");

    // R7 fault capture
    sendFault(2'd2, 2'd1, 3'd4, 2'd2, 32'h1234_5678);
    readCheck(12'h0A0, 32'h0000_2402, "R7 status fields");
    readCheck(12'h0B0, 32'h1234_5678, "R7 fault address");
    check("R10 irq off without enable", {31'd0, irq}, 32'h0);
    busWrite(12'h080, 32'h0000_0004);
    readCheck(12'h0B0, 32'h1234_5678, "R10 settle");
    check("R10 irq with enable", {31'd0, irq}, 32'h1);

    // R8 second fault keeps the first
    sendFault(2'd2, 2'd3, 3'd1, 2'd1, 32'hAAAA_0000);
    readCheck(12'h8A0, 32'h0000_2412, "R8 flag ORed, code kept");
    readCheck(12'h0B0, 32'h1234_5678, "R8 address kept");

    // R9 write-back of read value clears
    busWrite(12'h8A0, 32'h0000_2412);
    readCheck(12'h0A0, 32'h0, "R9 status cleared");
    readCheck(12'h0B0, 32'h0, "R9 address zero after clear");
    check("R10 irq drops", {31'd0, irq}, 32'h0);

    // R9 write of zero clears
    sendFault(2'd0, 2'd2, 3'd5, 2'd3, 32'hCAFE_0040);
    readCheck(12'h020, 32'h0000_3504, "R7 walk abort fields");
    busWrite(12'h020, 32'h0);
    readCheck(12'h020, 32'h0, "R9 zero write clears");
    readCheck(12'h030, 32'h0, "R9 zero write clears address");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule